// File: doc/BRIEF.md
# Sixteen-bit Serial-to-Parallel Deserializer with Phase-Selectable Word Clock

The block takes a serial bit stream clocked by a full-rate bit clock and groups every sixteen consecutive bits into one parallel word. Each serial bit is captured on a rising edge of the bit clock. A new word appears once every sixteen bit clocks, and a one-cycle strobe marks it. A run-time control picks the output lane of the earliest bit in each group: either the top lane (most-significant-first) or lane zero (least-significant-first).

Two word-rate clocks are derived from a four-bit count of bit clocks. Both have a 50% duty cycle. The first rises together with each new word. The second is a copy of the first, delayed by 0, 4, 8 or 12 bit clocks, which is a quarter of the word period per step. A two-bit selector sets the delay, so downstream logic can capture the word on a convenient edge. The order control and the delay selector are sampled only at a word boundary, so a change never splits a word. No alignment to a framing pattern is done: a word boundary falls every sixteen clocks after reset.

Top module: `serial_deser16`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state: `wordOut` reads 0, `wordValid` reads 0, and `wordClkA` and `wordClkB` both read 1.
- R2: Count the rising edges after `rst` falls from 1 as edge 1, 2, and so on. `wordValid` is high for exactly one cycle after edge 16, after edge 32, and after every sixteenth edge that follows. It is low at all other times.
- R3: With `lsbFirst` = 0 at a loading edge, the bit captured earliest among the sixteen bits of the group appears on `wordOut[15]`. The bit captured at the loading edge itself appears on `wordOut[0]`.
- R4: With `lsbFirst` = 1 at a loading edge, the earliest bit of the group appears on `wordOut[0]` and the latest on `wordOut[15]`.
- R5: `wordOut` changes only in the cycle in which `wordValid` is high. It holds its value for the sixteen cycles in between.
- R6: `wordClkA` is high for 8 bit clocks and low for 8. It rises in the same cycle in which `wordValid` is asserted.
- R7: `wordClkB` equals `wordClkA` delayed by 4×P bit clocks, where P is the unsigned value of `phaseSel` captured at the most recent loading edge (0 after reset).
- R8: `lsbFirst` and `phaseSel` are used only at a loading edge. Values they hold at any other edge have no effect on `wordOut` or `wordClkB`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate bit clock |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial data, one bit per clock |
| lsbFirst | input | 1 | 1: earliest bit goes to lane 0; 0: earliest bit goes to lane 15 |
| phaseSel | input | 2 | Delay of `wordClkB` in quarter word periods |
| wordOut | output | 16 | Parallel word |
| wordValid | output | 1 | One-cycle strobe when a new word is loaded |
| wordClkA | output | 1 | Word clock that rises with each new word |
| wordClkB | output | 1 | Word clock with selectable delay |

## Verification
The checker checks the timing skeleton on every cycle:
- the single-cycle strobe and where it falls in the count;
- that the word holds between loads;
- the level of both word clocks against the count and the captured phase;
- that the captured phase moves only at a load.

Only the bench's scenarios can show that the bits land on the right lanes in each order. The same holds for the latency after reset, and for the fact that control toggling in mid-word never reaches the output. For this, the bench compares the outputs with a model that records each serial bit at the edge where it is sent.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int DEF_WORD_W = 16;

  typedef struct packed {
    logic loadWord;   // this edge closes a group of bits
    logic lsbFirst;   // lane order to apply when loading
  } deserCtl_t;
endpackage

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lsbFirstIn,
  input  logic [1:0]                phaseSelIn,
  output deserCtl_t                 ctl,
  output logic [$clog2(WORD_W)-1:0] cntOut,
  output logic [1:0]                phaseCur,
  output logic                      wordClkA,
  output logic                      wordClkB
);
  localparam int CW      = $clog2(WORD_W);
  localparam int QUARTER = WORD_W / 4;
  localparam int HALF    = WORD_W / 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cntNext;
  logic [CW-1:0] shiftedNext;
  logic [1:0]    phaseReg;
  logic [1:0]    phaseNext;
  logic          boundary;

  always_comb begin
    boundary    = (cnt == CW'(WORD_W - 1));
    cntNext     = cnt + 1'b1;
    phaseNext   = boundary ? phaseSelIn : phaseReg;
    shiftedNext = cntNext - CW'(int'(phaseNext) * QUARTER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      phaseReg <= '0;
      wordClkA <= 1'b1;
      wordClkB <= 1'b1;
    end else begin
      cnt      <= cntNext;
      phaseReg <= phaseNext;
      wordClkA <= (cntNext < CW'(HALF));
      wordClkB <= (shiftedNext < CW'(HALF));
    end
  end

  always_comb begin
    ctl.loadWord = boundary;
    ctl.lsbFirst = lsbFirstIn;
  end

  assign cntOut   = cnt;
  assign phaseCur = phaseReg;
endmodule

// File: rtl/deser_datapath.sv
module deser_datapath
  import deser_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  deserCtl_t         ctl,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextShift;
  logic [WORD_W-1:0] revWord;

  assign nextShift = {shiftReg[WORD_W-2:0], serialIn};

  for (genvar g = 0; g < WORD_W; g++) begin : gLane
    assign revWord[g] = nextShift[WORD_W-1-g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      shiftReg  <= nextShift;
      wordValid <= ctl.loadWord;
      if (ctl.loadWord) begin
        wordOut <= ctl.lsbFirst ? revWord : nextShift;
      end
    end
  end
endmodule

// File: rtl/serial_deser16.sv
module serial_deser16
  import deser_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  logic              lsbFirst,
  input  logic [1:0]        phaseSel,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic              wordClkA,
  output logic              wordClkB
);
  localparam int CW = $clog2(WORD_W);

  deserCtl_t     ctl;
  logic [CW-1:0] cntVal;
  logic [1:0]    phaseCur;

  deser_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .lsbFirstIn (lsbFirst),
    .phaseSelIn (phaseSel),
    .ctl        (ctl),
    .cntOut     (cntVal),
    .phaseCur   (phaseCur),
    .wordClkA   (wordClkA),
    .wordClkB   (wordClkB)
  );

  deser_datapath #(.WORD_W(WORD_W)) uData (
    .clk       (clk),
    .rst       (rst),
    .serialIn  (serialIn),
    .ctl       (ctl),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );
endmodule

// File: rtl/deser_checker.sv
module deser_checker #(
  parameter int WORD_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [$clog2(WORD_W)-1:0] cnt,
  input logic [1:0]                phaseCur,
  input logic [WORD_W-1:0]         wordOut,
  input logic                      wordValid,
  input logic                      wordClkA,
  input logic                      wordClkB
);
  localparam int CW      = $clog2(WORD_W);
  localparam int QUARTER = WORD_W / 4;
  localparam int HALF    = WORD_W / 2;

  logic [CW-1:0] delayedCnt;
  assign delayedCnt = cnt - CW'(int'(phaseCur) * QUARTER);

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  assert_valid_at_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> (cnt == '0));

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wordValid |-> $stable(wordOut));

  assert_clka_level_R6: assert property (@(posedge clk) disable iff (rst)
    wordClkA == (cnt < CW'(HALF)));

  assert_clka_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wordClkA) |-> (cnt == '0));

  assert_clkb_delay_R7: assert property (@(posedge clk) disable iff (rst)
    wordClkB == (delayedCnt < CW'(HALF)));

  assert_phase_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(phaseCur) |-> wordValid);
endmodule

bind serial_deser16 deser_checker #(.WORD_W(WORD_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .cnt       (cntVal),
  .phaseCur  (phaseCur),
  .wordOut   (wordOut),
  .wordValid (wordValid),
  .wordClkA  (wordClkA),
  .wordClkB  (wordClkB)
);

// File: tb/sim_serial_deser16.sv
module sim_serial_deser16;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        serialIn = 1'b0;
  logic        lsbFirst = 1'b0;
  logic [1:0]  phaseSel = 2'd0;
  logic [15:0] wordOut;
  logic        wordValid;
  logic        wordClkA;
  logic        wordClkB;

  serial_deser16 u0 (
    .clk(clk), .rst(rst), .serialIn(serialIn), .lsbFirst(lsbFirst),
    .phaseSel(phaseSel), .wordOut(wordOut), .wordValid(wordValid),
    .wordClkA(wordClkA), .wordClkB(wordClkB)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  int          cntM;
  int          phaseM;
  logic [15:0] wordM;
  logic        validM;
  logic        bitsM [16];
  int          sinceRst;
  string       wordTag = "";

  function automatic logic clkLevel(int c, int p);
    return (((c - 4 * p) % 16 + 16) % 16) < 8;
  endfunction

  function automatic logic [15:0] buildWord(logic ord);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) begin
      if (ord) w[i] = bitsM[i];
      else     w[15 - i] = bitsM[i];
    end
    return w;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) @(negedge clk);
    check("R1 word",  wordOut, 16'h0);
    check("R1 valid", {15'b0, wordValid}, 16'h0);
    check("R1 clkA",  {15'b0, wordClkA}, 16'h1);
    check("R1 clkB",  {15'b0, wordClkB}, 16'h1);
    cntM = 0; phaseM = 0; wordM = '0; validM = 0; sinceRst = 0;
  endtask

  // called at a negedge: drive inputs, predict post-edge state, compare
  task automatic step(logic b, logic ord, logic [1:0] ph);
    logic ordUsed;
    rst = 1'b0; serialIn = b; lsbFirst = ord; phaseSel = ph;
    bitsM[cntM] = b;
    validM = 1'b0;
    ordUsed = ord;
    if (cntM == 15) begin
      wordM  = buildWord(ord);
      validM = 1'b1;
      phaseM = ph;
    end
    cntM = (cntM + 1) % 16;
    sinceRst++;
    @(posedge clk);
    @(negedge clk);
    if (validM) begin
      if (wordTag != "") check(wordTag, wordOut, wordM);
      else if (ordUsed)  check("R4 lsb-first word", wordOut, wordM);
      else               check("R3 msb-first word", wordOut, wordM);
      if (sinceRst == 16) check("R2 first word latency", {15'b0, wordValid}, 16'h1);
    end else begin
      check("R5 word hold", wordOut, wordM);
    end
    check("R2 valid strobe", {15'b0, wordValid}, {15'b0, validM});
    check("R6 clkA", {15'b0, wordClkA}, {15'b0, clkLevel(cntM, 0)});
    check("R7 clkB", {15'b0, wordClkB}, {15'b0, clkLevel(cntM, phaseM)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    doReset(3);

    // directed: each phase, both orders, alternating and constant data
    for (int p = 0; p < 4; p++) begin
      for (int w = 0; w < 3; w++) begin
        for (int k = 0; k < 16; k++) step(1'((k + w) & 1), 1'b0, 2'(p));
      end
    end
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 16; k++) step(k == 0, 1'b1, 2'd2);
    end
    for (int k = 0; k < 16; k++) step(k == 0, 1'b0, 2'd1);

    // R8: controls toggle mid-word, settle only at the loading edge
    wordTag = "R8 mid-word order change ignored";
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < 16; k++) begin
        if (k == 15) step(1'($urandom), 1'(w & 1), 2'(w));
        else         step(1'($urandom), 1'(~(w & 1) ^ (k & 1)), 2'($urandom));
      end
    end
    wordTag = "";

    // random traffic with random control changes
    for (int c = 0; c < 1600; c++) begin
      step(1'($urandom), 1'($urandom_range(0, 3) == 0 ? ~lsbFirst : lsbFirst),
           ($urandom_range(0, 7) == 0) ? 2'($urandom) : phaseSel);
    end

    // reset in mid-word, then more random traffic
    for (int k = 0; k < 5; k++) step(1'($urandom), 1'b1, 2'd3);
    doReset(2);
    for (int c = 0; c < 800; c++) begin
      step(1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0) ? 2'($urandom) : phaseSel);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule